// File: doc/BRIEF.md
# Multi-Channel DMA Request/Acknowledge Sequencer

This block runs the external request and acknowledge handshake of a small multi-channel DMA engine. Each channel has a request line and is configured with a transfer mode, a block size (data items per block) and a transfer count (number of blocks). Pending requests are arbitrated by fixed priority. The granted channel then produces one address-phase strobe per data item toward a modelled bus interface, with a matching acknowledge line. An end-of-transfer flag marks the final item of the programmed count. A 3-bit status code and an optional interrupt report normal completion or a forced stop.

After every grant the sequencer always spends idle cycles before the next grant, and it samples all channels during them. A request raised on a busy channel before the last item of its grant is dropped. One shared pin carries either the stop input or the end-of-transfer output, selected by a configuration bit. A stop only counts once it has been held for a minimum number of cycles. A pulse on `start_i` loads every channel's remaining count from its configuration. A pulse on `clr_i` clears the status and the interrupt.

Top module: `dma_hs_seq`

## Requirements
- R1: Among pending channels the lowest-numbered one is granted. A grant produces one strobe per cycle with `strobe_ch_o` equal to the granted channel index.
- R2: After a grant ends, at least one cycle without a strobe follows. A higher-priority channel whose request arrives in that cycle is granted before a lower one that is already pending.
- R3: A request on the granted channel during any item except the last item of its grant is ignored. A request during the last item re-arms the channel if it still has blocks left.
- R4: Burst mode (`cfg_mode` = 2'b00): one request yields block size × count strobes back to back.
- R5: Block mode (2'b10) yields one block of block-size strobes per request. Step mode (2'b01) yields a single strobe per request, whatever the block size.
- R6: Demand mode (2'b11) moves one item per cycle and ends the grant at an item whose cycle sees the request low. A held request runs the whole count.
- R7: `ack_o` is one-hot on bit `strobe_ch_o` while a strobe is active and `ack_oe_i` is 1. Otherwise `ack_o` is 0.
- R8: `eot_o` pulses exactly once per completed count, in the cycle of the final item of the final block. It pulses only when `eot_oe_i` is 1 and the channel's `cfg_int_i` bit (internal access) is 0.
- R9: A stop on `stop_i` is recognised only after 5 consecutive high cycles. A 4-cycle pulse has no effect.
- R10: A recognised stop ends the active grant, cancels that channel's remaining blocks and sets `status_o` to 3'b010. If `irq_en_i` is 1, it also sets `irq_o`.
- R11: With `pin_stop_sel_i` = 1, `eot_o` and `eot_drv_o` are 0. With `pin_stop_sel_i` = 0, `stop_i` is ignored and `eot_drv_o` equals `eot_oe_i`.
- R12: Completion of a count sets `status_o` to 3'b001, and sets `irq_o` only if `irq_en_i` is 1. A `clr_i` pulse returns both to 0.
- R13: After reset, `status_o` = 3'b000, and `irq_o`, `strobe_o`, `ack_o` and `eot_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load all remaining counts from configuration, clear pending requests |
| clr_i | input | 1 | Write-one-to-clear pulse for status and interrupt |
| req_i | input | NCH | Per-channel transfer request |
| cfg_mode_i | input | 2*NCH | Per-channel mode: 00 burst, 01 step, 10 block, 11 demand |
| cfg_blk_i | input | BLK_W*NCH | Per-channel items per block (0 treated as 1) |
| cfg_cnt_i | input | CNT_W*NCH | Per-channel number of blocks |
| cfg_int_i | input | NCH | Per-channel: final access is internal, suppress end-of-transfer |
| ack_oe_i | input | 1 | Enable for acknowledge outputs |
| eot_oe_i | input | 1 | Enable for end-of-transfer output |
| pin_stop_sel_i | input | 1 | Shared pin function: 1 stop input, 0 end-of-transfer output |
| irq_en_i | input | 1 | Interrupt enable |
| stop_i | input | 1 | Stop request from the shared pin |
| strobe_o | output | 1 | Address-phase strobe, one per data item |
| strobe_ch_o | output | CH_W | Channel owning the current strobe |
| ack_o | output | NCH | Per-channel acknowledge |
| eot_o | output | 1 | End-of-transfer pulse |
| eot_drv_o | output | 1 | Shared pin is driven as output |
| status_o | output | 3 | 000 idle, 001 completed, 010 stop error |
| irq_o | output | 1 | Interrupt |

## Verification
A wrong remaining count or item counter shows up at the ports as a wrong number of strobes per request, or as `eot_o` on the wrong strobe. The bench sees either one within the grant, a few cycles after the request. A stuck pending bit or a broken arbiter makes channels appear in the wrong order in the logged strobe sequence, at the first grant after the gap. A stop filter that counts wrongly changes `status_o` one cycle early or late relative to the fifth high cycle. The bench pins the stop on both sides of that threshold.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic [1:0] {
        M_BURST  = 2'b00,
        M_STEP   = 2'b01,
        M_BLOCK  = 2'b10,
        M_DEMAND = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        S_ARB  = 2'b00,
        S_XFER = 2'b01,
        S_GAP  = 2'b10
    } seq_state_e;

    localparam logic [2:0] ST_IDLE = 3'b000;
    localparam logic [2:0] ST_DONE = 3'b001;
    localparam logic [2:0] ST_STOP = 3'b010;

    // Modes that move one item per grant decision
    function automatic logic single_item(input xfer_mode_e m);
        return (m == M_STEP) || (m == M_DEMAND);
    endfunction

    // Whether a grant carries on after a block finishes
    function automatic logic keeps_going(input xfer_mode_e m, input logic req);
        return (m == M_BURST) || ((m == M_DEMAND) && req);
    endfunction

endpackage

// File: rtl/dma_hs_stopflt.sv
module dma_hs_stopflt #(
    parameter int LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic din,
    output logic hit
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !en || !din) begin
            run_q <= '0;
        end else if (run_q != CW'(LEN)) begin
            run_q <= run_q + CW'(1);
        end
    end

    // fires once, on the LEN-th consecutive high sample
    assign hit = en && din && (run_q == CW'(LEN - 1));
endmodule

// File: rtl/dma_hs_arb.sv
module dma_hs_arb #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  pend,
    output logic            any,
    output logic [CH_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) idx = CH_W'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/dma_hs_chan.sv
module dma_hs_chan #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt_cfg,
    input  logic             req,
    input  logic             granted,
    input  logic             busy,
    input  logic             last,
    input  logic             dec,
    input  logic             kill,
    output logic             pend,
    output logic             active,
    output logic             final_one
);
    logic [CNT_W-1:0] rem_q, rem_nx;

    always_comb begin
        rem_nx = rem_q;
        if (load)      rem_nx = cnt_cfg;
        else if (kill) rem_nx = '0;
        else if (dec)  rem_nx = rem_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            pend  <= 1'b0;
        end else begin
            rem_q <= rem_nx;
            if (load || granted || kill) begin
                pend <= 1'b0;
            end else if (req && (rem_nx != '0) && (!busy || last)) begin
                pend <= 1'b1;
            end
        end
    end

    assign active    = (rem_q != '0);
    assign final_one = (rem_q == CNT_W'(1));
endmodule

// File: rtl/dma_hs_seq.sv
module dma_hs_seq
    import dma_hs_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int BLK_W    = 4,
    parameter int CNT_W    = 8,
    parameter int STOP_LEN = 5,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 clr_i,
    input  logic [NCH-1:0]       req_i,
    input  logic [2*NCH-1:0]     cfg_mode_i,
    input  logic [BLK_W*NCH-1:0] cfg_blk_i,
    input  logic [CNT_W*NCH-1:0] cfg_cnt_i,
    input  logic [NCH-1:0]       cfg_int_i,
    input  logic                 ack_oe_i,
    input  logic                 eot_oe_i,
    input  logic                 pin_stop_sel_i,
    input  logic                 irq_en_i,
    input  logic                 stop_i,
    output logic                 strobe_o,
    output logic [CH_W-1:0]      strobe_ch_o,
    output logic [NCH-1:0]       ack_o,
    output logic                 eot_o,
    output logic                 eot_drv_o,
    output logic [2:0]           status_o,
    output logic                 irq_o
);
    seq_state_e       st_q;
    logic [CH_W-1:0]  gch_q;
    logic [BLK_W-1:0] item_q;
    logic [2:0]       status_q;
    logic             irq_q;

    xfer_mode_e       mode_a [NCH];
    logic [BLK_W-1:0] blk_a  [NCH];
    logic [NCH-1:0]   pend, active, final_one;

    logic             any;
    logic [CH_W-1:0]  idx;
    logic             stop_hit;
    logic             xfer, item_last, blk_done, fin, grant_end;
    xfer_mode_e       mode_g;
    logic [BLK_W-1:0] eff_blk;

    assign xfer      = (st_q == S_XFER);
    assign mode_g    = mode_a[gch_q];
    assign eff_blk   = (single_item(mode_g) || blk_a[gch_q] == '0) ? BLK_W'(1) : blk_a[gch_q];
    assign item_last = (item_q == eff_blk - BLK_W'(1));
    assign blk_done  = xfer && item_last;
    assign fin       = blk_done && final_one[gch_q];
    assign grant_end = xfer && (stop_hit || fin ||
                                (blk_done && !keeps_going(mode_g, req_i[gch_q])));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign mode_a[c] = xfer_mode_e'(cfg_mode_i[2*c +: 2]);
            assign blk_a[c]  = cfg_blk_i[BLK_W*c +: BLK_W];

            dma_hs_chan #(.CNT_W(CNT_W)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .load      (start_i),
                .cnt_cfg   (cfg_cnt_i[CNT_W*c +: CNT_W]),
                .req       (req_i[c]),
                .granted   ((st_q == S_ARB) && any && (idx == CH_W'(c))),
                .busy      (xfer && (gch_q == CH_W'(c))),
                .last      (grant_end),
                .dec       (blk_done && (gch_q == CH_W'(c))),
                .kill      (stop_hit && xfer && (gch_q == CH_W'(c))),
                .pend      (pend[c]),
                .active    (active[c]),
                .final_one (final_one[c])
            );
        end
    endgenerate

    dma_hs_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .pend (pend & active),
        .any  (any),
        .idx  (idx)
    );

    dma_hs_stopflt #(.LEN(STOP_LEN)) u_stop (
        .clk (clk),
        .rst (rst),
        .en  (pin_stop_sel_i),
        .din (stop_i),
        .hit (stop_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_ARB;
            gch_q  <= '0;
            item_q <= '0;
        end else begin
            unique case (st_q)
                S_ARB: begin
                    if (any) begin
                        st_q   <= S_XFER;
                        gch_q  <= idx;
                        item_q <= '0;
                    end
                end
                S_XFER: begin
                    if (grant_end) begin
                        st_q   <= S_GAP;
                        item_q <= '0;
                    end else if (item_last) begin
                        item_q <= '0;
                    end else begin
                        item_q <= item_q + BLK_W'(1);
                    end
                end
                default: st_q <= S_ARB;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= ST_IDLE;
            irq_q    <= 1'b0;
        end else if (stop_hit) begin
            status_q <= ST_STOP;
            irq_q    <= irq_q || irq_en_i;
        end else if (fin) begin
            status_q <= ST_DONE;
            irq_q    <= irq_q || irq_en_i;
        end else if (clr_i) begin
            status_q <= ST_IDLE;
            irq_q    <= 1'b0;
        end
    end

    assign strobe_o    = xfer;
    assign strobe_ch_o = xfer ? gch_q : '0;
    assign ack_o       = (xfer && ack_oe_i) ? (NCH'(1) << gch_q) : '0;
    assign eot_drv_o   = !pin_stop_sel_i && eot_oe_i;
    assign eot_o       = eot_drv_o && fin && !cfg_int_i[gch_q];
    assign status_o    = status_q;
    assign irq_o       = irq_q;
endmodule

// File: rtl/dma_hs_chk.sv
module dma_hs_chk
    import dma_hs_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            strobe_o,
    input logic [CH_W-1:0] strobe_ch_o,
    input logic [NCH-1:0]  ack_o,
    input logic            eot_o,
    input logic            eot_drv_o,
    input logic [2:0]      status_o,
    input logic            irq_o,
    input logic            pin_stop_sel_i,
    input logic            stop_i,
    input logic            irq_en_i,
    input logic            ack_oe_i
);
    a_r7_ack_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_o));

    a_r7_ack_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (|ack_o) |-> (strobe_o && ack_oe_i));

    a_r2_gap_on_switch: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && $past(strobe_o)) |-> (strobe_ch_o == $past(strobe_ch_o)));

    a_r11_pin_shared: assert property (@(posedge clk) disable iff (rst)
        pin_stop_sel_i |-> (!eot_drv_o && !eot_o));

    a_r8_eot_on_strobe: assert property (@(posedge clk) disable iff (rst)
        eot_o |-> (strobe_o && eot_drv_o));

    a_r10_stop_cause: assert property (@(posedge clk) disable iff (rst)
        (status_o == ST_STOP && $past(status_o) != ST_STOP)
            |-> ($past(stop_i) && $past(pin_stop_sel_i)));

    a_r12_irq_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(irq_en_i));
endmodule

bind dma_hs_seq dma_hs_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .strobe_o       (strobe_o),
    .strobe_ch_o    (strobe_ch_o),
    .ack_o          (ack_o),
    .eot_o          (eot_o),
    .eot_drv_o      (eot_drv_o),
    .status_o       (status_o),
    .irq_o          (irq_o),
    .pin_stop_sel_i (pin_stop_sel_i),
    .stop_i         (stop_i),
    .irq_en_i       (irq_en_i),
    .ack_oe_i       (ack_oe_i)
);

// File: tb/sim_dma_hs_seq.sv
`timescale 1ns/1ps
module sim_dma_hs_seq;
    localparam int NCH = 4, BLK_W = 4, CNT_W = 8, CH_W = 2;

    logic clk = 0, rst = 1, start_i = 0, clr_i = 0;
    logic [NCH-1:0]       req_i = '0;
    logic [2*NCH-1:0]     cfg_mode_i = '0;
    logic [BLK_W*NCH-1:0] cfg_blk_i = '0;
    logic [CNT_W*NCH-1:0] cfg_cnt_i = '0;
    logic [NCH-1:0]       cfg_int_i = '0;
    logic ack_oe_i = 1, eot_oe_i = 1, pin_stop_sel_i = 0, irq_en_i = 1, stop_i = 0;
    logic            strobe_o, eot_o, eot_drv_o, irq_o;
    logic [CH_W-1:0] strobe_ch_o;
    logic [NCH-1:0]  ack_o;
    logic [2:0]      status_o;

    int checks = 0, errors = 0;
    int tot, eot_n, eot_at, ack_bad;
    int per_ch [NCH];
    int seq [16];
    logic mon_clr = 0;

    always #4 clk = ~clk;

    dma_hs_seq u0 (.*);

    always @(negedge clk) begin
        if (mon_clr) begin
            tot = 0; eot_n = 0; eot_at = 0; ack_bad = 0;
            for (int i = 0; i < NCH; i++) per_ch[i] = 0;
        end else if (!rst) begin
            if (strobe_o) begin
                if (tot < 16) seq[tot] = int'(strobe_ch_o);
                tot++;
                per_ch[strobe_ch_o]++;
                if (ack_o != (ack_oe_i ? (NCH'(1) << strobe_ch_o) : '0)) ack_bad++;
            end else if (ack_o != '0) ack_bad++;
            if (eot_o) begin eot_n++; eot_at = tot; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int ch, input int m, input int blk, input int cnt, input bit intl);
        cfg_mode_i[2*ch +: 2]         = 2'(m);
        cfg_blk_i[BLK_W*ch +: BLK_W]  = BLK_W'(blk);
        cfg_cnt_i[CNT_W*ch +: CNT_W]  = CNT_W'(cnt);
        cfg_int_i[ch]                 = intl;
    endtask

    // clear monitor, clear status, load counts
    task automatic fresh();
        mon_clr = 1; clr_i = 1; cyc(1);
        mon_clr = 0; clr_i = 0; start_i = 1; cyc(1);
        start_i = 0;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        req_i = m; cyc(1); req_i = '0;
    endtask

    // wait for the k-th strobe seen from now, then request in that same cycle
    task automatic req_on_strobe(input int ch, input int k);
        int n = 0;
        for (int t = 0; t < 200 && n < k; t++) begin
            @(negedge clk);
            if (strobe_o) n++;
        end
        req_i[ch] = 1'b1; cyc(1); req_i[ch] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 0;
        // R13 reset state
        chk("R13 status", int'(status_o), 0);
        chk("R13 irq", int'(irq_o), 0);
        chk("R13 strobe", int'(strobe_o), 0);
        chk("R13 ack", int'(ack_o), 0);
        chk("R13 eot", int'(eot_o), 0);

        // R4 R8 R12 burst sweep over every channel, block size and count
        for (int ch = 0; ch < NCH; ch++)
            for (int b = 1; b <= 4; b++)
                for (int c = 1; c <= 3; c++) begin
                    cfg(ch, 0, b, c, 0);
                    fresh();
                    pulse(NCH'(1) << ch);
                    cyc(b * c + 6);
                    chk("R4 burst strobes", per_ch[ch], b * c);
                    chk("R8 eot count", eot_n, 1);
                    chk("R8 eot on last item", eot_at, b * c);
                    chk("R12 done status", int'(status_o), 1);
                    chk("R12 irq set", int'(irq_o), 1);
                end
        clr_i = 1; cyc(1); clr_i = 0;
        chk("R12 clear status", int'(status_o), 0);
        chk("R12 clear irq", int'(irq_o), 0);
        chk("R7 ack tracking", ack_bad, 0);

        // R5 block mode: one block per request
        cfg(0, 2, 3, 2, 0);
        fresh();
        pulse(4'b0001); cyc(10);
        chk("R5 block one request", per_ch[0], 3);
        chk("R5 block not done", int'(status_o), 0);
        pulse(4'b0001); cyc(10);
        chk("R5 block second request", per_ch[0], 6);
        chk("R5 block done", int'(status_o), 1);

        // R5 step mode ignores block size
        cfg(0, 1, 3, 3, 0);
        fresh();
        pulse(4'b0001); cyc(10);
        chk("R5 step single item", per_ch[0], 1);

        // R6 demand, request held
        cfg(3, 3, 4, 5, 0);
        fresh();
        req_i[3] = 1; cyc(15); req_i[3] = 0; cyc(3);
        chk("R6 demand held", per_ch[3], 5);
        chk("R6 demand eot", eot_n, 1);
        chk("R6 demand done", int'(status_o), 1);
        // R6 demand, one-cycle request stops after one item
        fresh();
        pulse(4'b1000); cyc(10);
        chk("R6 demand pulse", per_ch[3], 1);
        chk("R6 demand pulse status", int'(status_o), 0);

        // R3 early re-request ignored, last-item request re-arms
        cfg(2, 2, 4, 3, 0);
        fresh();
        pulse(4'b0100);
        req_on_strobe(2, 2);
        cyc(12);
        chk("R3 early request ignored", per_ch[2], 4);
        pulse(4'b0100);
        req_on_strobe(2, 4);
        cyc(12);
        chk("R3 last item re-arms", per_ch[2], 12);
        chk("R3 count finished", int'(status_o), 1);

        // R1 R2 priority in the gap
        cfg(1, 2, 2, 2, 0);
        cfg(0, 2, 1, 1, 0);
        fresh();
        pulse(4'b0010);
        req_on_strobe(1, 2);      // re-arm ch1 on its last item
        pulse(4'b0001);           // ch0 requests in the gap cycle
        cyc(15);
        chk("R2 total strobes", tot, 5);
        chk("R1 first grant ch1", seq[0], 1);
        chk("R2 gap winner ch0", seq[2], 0);
        chk("R1 then ch1", seq[3], 1);
        chk("R1 ch0 items", per_ch[0], 1);

        // R8 internal access suppresses eot
        cfg(1, 0, 2, 1, 1);
        fresh();
        pulse(4'b0010); cyc(8);
        chk("R8 internal no eot", eot_n, 0);
        chk("R8 internal still done", int'(status_o), 1);
        cfg(1, 0, 2, 1, 0);
        eot_oe_i = 0;
        fresh();
        pulse(4'b0010); cyc(8);
        chk("R8 eot disabled", eot_n, 0);
        chk("R11 drive follows enable", int'(eot_drv_o), 0);
        eot_oe_i = 1;

        // R7 acknowledge disabled
        ack_oe_i = 0;
        fresh();
        pulse(4'b0010); cyc(8);
        chk("R7 strobes without ack", per_ch[1], 2);
        chk("R7 no ack when disabled", ack_bad, 0);
        ack_oe_i = 1;

        // R12 interrupt disabled
        irq_en_i = 0;
        fresh();
        pulse(4'b0010); cyc(8);
        chk("R12 done without irq", int'(status_o), 1);
        chk("R12 irq masked", int'(irq_o), 0);
        irq_en_i = 1;

        // R9 R10 R11 stop function
        cfg(0, 0, 4, 8, 0);
        pin_stop_sel_i = 1;
        fresh();
        pulse(4'b0001); cyc(4);
        chk("R11 eot pin released", int'(eot_drv_o), 0);
        stop_i = 1; cyc(4); stop_i = 0; cyc(2);
        chk("R9 short stop ignored", int'(status_o), 0);
        chk("R9 still moving", int'(strobe_o), 1);
        stop_i = 1; cyc(5);
        chk("R10 stop status", int'(status_o), 2);
        chk("R10 stop irq", int'(irq_o), 1);
        stop_i = 0; cyc(3);
        chk("R10 transfer aborted", int'(strobe_o), 0);
        chk("R10 fewer items", int'(per_ch[0] < 32), 1);
        chk("R11 no eot in stop mode", eot_n, 0);
        pulse(4'b0001); cyc(4);
        chk("R10 count cancelled", int'(strobe_o), 0);
        clr_i = 1; cyc(1); clr_i = 0;
        chk("R12 clear after stop", int'(status_o), 0);
        chk("R12 irq clear after stop", int'(irq_o), 0);

        pin_stop_sel_i = 0;
        fresh();
        pulse(4'b0001); cyc(3);
        stop_i = 1; cyc(8); stop_i = 0; cyc(30);
        chk("R11 stop ignored in eot mode", per_ch[0], 32);
        chk("R11 completes normally", int'(status_o), 1);
        chk("R11 eot driven", eot_n, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule